// File: doc/BRIEF.md
# Vector Upper-Half Widening Extension Unit

This execution unit belongs to a 256-bit SIMD datapath. It takes one instruction word and one 256-bit operand that has already been read from the register file. It then produces a 256-bit result. The vector is split into 128-bit lanes. In each lane, the narrow elements that sit in the upper 64 bits are widened to twice their size and fill the whole lane. The extension is signed or unsigned. Four size steps are supported: byte to halfword, halfword to word, word to doubleword and doubleword to quadword.

The unit is a single registered pipeline stage with a valid/ready handshake. It returns the result together with the destination register index taken from the instruction. It also returns an illegal-operation flag for words it does not recognise. Register-file access, writeback and hazard tracking are handled by the surrounding core.

Top module: `xh_unit`

## Requirements
- R1: The instruction word has three fields. Bits 31:15 must equal `0111_0110_1001_1110_1`. Bits 14:10 hold the sub-opcode. Bits 4:0 hold the destination index, which is returned on `out_dest`. Bits 9:5 are not used by this unit.
- R2: Sub-opcodes `11000`, `11001`, `11010` and `11011` select sign extension for the steps 8→16, 16→32, 32→64 and 64→128 bits respectively.
- R3: Sub-opcodes `11100` to `11111` select the same four steps in the same order, but with zero extension.
- R4: Elements are counted from bit 0 upward, so narrow element k occupies bits k·N+N-1:k·N. Let the wide width be W and let m = 256/(2W). Result element i (for i < m) comes from narrow element i+m. Result element i+m comes from narrow element i+3m.
- R5: For the 64→128 steps, result bits 127:0 come from source bits 127:64, and result bits 255:128 come from source bits 255:192.
- R6: Sign extension copies the top bit of the narrow element into the upper half of the wide element. Zero extension fills that upper half with zeros. This includes narrow elements that hold the most negative value and elements that are all ones.
- R7: An accepted word with a wrong prefix, or with sub-opcode bits 14:13 not equal to `11`, sets `out_illegal` to 1. In that case `out_data` keeps its previous value, and `out_dest` still takes bits 4:0.
- R8: `in_ready` equals `!out_valid || out_ready`. When `in_ready` is high, `out_valid` takes the value of `in_valid` on the next edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_dest` and `out_illegal` do not change.
- R10: A synchronous active-low reset (`rst_n`) clears `out_valid`, `out_data`, `out_dest` and `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Stage can accept an operation |
| in_instr | input | 32 | Instruction word |
| in_src | input | 256 | Source vector |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 256 | Widened result |
| out_dest | output | 5 | Destination register index |
| out_illegal | output | 1 | Word was not a recognised operation |

## Verification
The bench builds the unit with its default parameters: a 256-bit vector and 128-bit lanes. With these values there are two lanes, so the crossing from the lower lane to the upper lane is exercised, and all four size steps, including the 64→128 step, are in reach. A behavioural model computes the expected results from the index formula in R4. It is fed random vectors, a byte-index pattern that exposes any misplaced element, and per-size most-negative, most-positive and all-ones patterns. The handshake is exercised with random and held back-pressure.

// File: rtl/xh_pkg.sv
// Package xh_pkg
// Holds the shared constants and types of the upper-half widening unit.
// Assumes a 32-bit instruction word with a 5-bit register index field.
package xh_pkg;
    localparam int unsigned INSTR_W   = 32;
    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned PREFIX_W  = 17;
    localparam logic [PREFIX_W-1:0] XH_PREFIX = 17'b0111_0110_1001_1110_1;

    // Size step: the narrow width is 8 << size
    typedef enum logic [1:0] {
        SZ_8_16   = 2'd0,
        SZ_16_32  = 2'd1,
        SZ_32_64  = 2'd2,
        SZ_64_128 = 2'd3
    } xh_size_e;

    typedef struct packed {
        logic                 legal;
        logic                 zext;
        xh_size_e             size;
        logic [REG_IDX_W-1:0] dest;
    } xh_op_t;
endpackage

// File: rtl/xh_decode.sv
// Module xh_decode
// Turns an instruction word into an operation descriptor.
// The word must have the fixed prefix in bits 31:15 and 11 in bits 14:13.
// Bit 12 selects zero extension, and bits 11:10 select the size step.
// Assumes the xh_pkg field layout. The source index field is not used.
module xh_decode
    import xh_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output xh_op_t             op
);
    localparam int unsigned PREFIX_LSB = INSTR_W - PREFIX_W;

    // Field split and legality check
    always_comb begin
        op.legal = (instr[INSTR_W-1:PREFIX_LSB] == XH_PREFIX) &&
                   (instr[PREFIX_LSB-1 -: 2] == 2'b11);
        op.zext  = instr[12];
        op.size  = xh_size_e'(instr[11:10]);
        op.dest  = instr[REG_IDX_W-1:0];
    end
endmodule

// File: rtl/xh_widen.sv
// Module xh_widen
// Combinational datapath. In each lane it builds the widened result for all
// four size steps, then selects one of them by size.
// Assumes that LANE_W divides VEC_W and that LANE_W/2 is at least 64.
module xh_widen
    import xh_pkg::*;
#(
    parameter int unsigned VEC_W  = 256,
    parameter int unsigned LANE_W = 128
) (
    input  logic [VEC_W-1:0] src,
    input  xh_size_e         size,
    input  logic             zext,
    output logic [VEC_W-1:0] res
);
    localparam int unsigned LANES  = VEC_W / LANE_W;
    localparam int unsigned HALF_W = LANE_W / 2;
    localparam int unsigned NSIZES = 4;

    logic [NSIZES-1:0][VEC_W-1:0] cand;

    for (genvar s = 0; s < NSIZES; s++) begin : g_size
        localparam int unsigned NW  = 8 << s;
        localparam int unsigned WW  = 2 * NW;
        localparam int unsigned NEL = HALF_W / NW;
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            for (genvar e = 0; e < NEL; e++) begin : g_elem
                logic [NW-1:0] narrow;
                logic          fill;
                // Pick the upper-half narrow element and its extension bit
                assign narrow = src[l*LANE_W + HALF_W + e*NW +: NW];
                assign fill   = ~zext & narrow[NW-1];
                // Place the widened element in the lane
                assign cand[s][l*LANE_W + e*WW +: WW] = {{NW{fill}}, narrow};
            end
        end
    end

    // Select the result for the requested size step
    assign res = cand[size];
endmodule

// File: rtl/xh_unit.sv
// Module xh_unit
// Top of the widening unit. It decodes the word, widens the source vector
// and captures everything in a single output register with a valid/ready
// handshake. Assumes a synchronous active-low reset and a consumer that
// keeps out_ready stable within a cycle.
module xh_unit
    import xh_pkg::*;
#(
    parameter int unsigned VEC_W  = 256,
    parameter int unsigned LANE_W = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [INSTR_W-1:0]   in_instr,
    input  logic [VEC_W-1:0]     in_src,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [VEC_W-1:0]     out_data,
    output logic [REG_IDX_W-1:0] out_dest,
    output logic                 out_illegal
);
    xh_op_t           op;
    logic [VEC_W-1:0] wide;

    xh_decode u_dec (
        .instr (in_instr),
        .op    (op)
    );

    xh_widen #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_wid (
        .src  (in_src),
        .size (op.size),
        .zext (op.zext),
        .res  (wide)
    );

    // The stage accepts when empty or when it is draining
    assign in_ready = ~out_valid | out_ready;

    // Output register: capture on acceptance, hold while stalled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_dest    <= '0;
            out_illegal <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_dest    <= op.dest;
                out_illegal <= ~op.legal;
                if (op.legal) begin
                    out_data <= wide;
                end
            end
        end
    end

    // R9
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) &&
        $stable(out_dest) && $stable(out_illegal));

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R7
    illegal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !op.legal |=> out_illegal && $stable(out_data));

    // R2
    legal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && op.legal |=> !out_illegal);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !out_illegal);
endmodule

// File: tb/xh_unit_tb_top.sv
`timescale 1ns/1ps
module xh_unit_tb_top;
    localparam int VEC_W = 256;
    localparam logic [16:0] PFX = 17'b0111_0110_1001_1110_1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_instr = '0;
    logic [255:0] in_src = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [255:0] out_data;
    logic [4:0]   out_dest;
    logic         out_illegal;

    int    checks = 0;
    int    errors = 0;
    string tag = "R10";

    logic         m_valid = 1'b0;
    logic [255:0] m_data = '0;
    logic [4:0]   m_dest = '0;
    logic         m_ill = 1'b0;

    always #2 clk = ~clk;

    xh_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .in_src(in_src), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_dest(out_dest),
        .out_illegal(out_illegal)
    );

    // Reference widening built from the element index formula
    function automatic logic [255:0] ref_widen(input logic [255:0] s, input logic [4:0] sub);
        int n = 8 << sub[1:0];
        int w = 2 * n;
        int mx = 256 / (2 * w);
        logic [255:0] r = '0;
        for (int i = 0; i < 2 * mx; i++) begin
            int k = (i < mx) ? i + mx : (i - mx) + 3 * mx;
            for (int b = 0; b < w; b++)
                r[i*w+b] = (b < n) ? s[k*n+b] : (sub[2] ? 1'b0 : s[k*n+n-1]);
        end
        return r;
    endfunction

    // Cycle model of the stage
    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 1'b0; m_data = '0; m_dest = '0; m_ill = 1'b0;
        end else if (!m_valid || out_ready) begin
            m_valid = in_valid;
            if (in_valid) begin
                m_dest = in_instr[4:0];
                if (in_instr[31:15] == PFX && in_instr[14:13] == 2'b11) begin
                    m_ill = 1'b0;
                    m_data = ref_widen(in_src, in_instr[14:10]);
                end else begin
                    m_ill = 1'b1;
                end
            end
        end
    end

    task automatic cmp(input string what, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        cmp("out_valid", {255'd0, out_valid}, {255'd0, m_valid});
        cmp("in_ready", {255'd0, in_ready}, {255'd0, (!m_valid || out_ready)});
        if (m_valid) begin
            cmp("out_data", out_data, m_data);
            cmp("out_dest", {251'd0, out_dest}, {251'd0, m_dest});
            cmp("out_illegal", {255'd0, out_illegal}, {255'd0, m_ill});
        end
    endtask

    task automatic step(input logic v, input logic [31:0] ins, input logic [255:0] s, input logic rdy);
        @(negedge clk);
        compare();
        in_valid = v; in_instr = ins; in_src = s; out_ready = rdy;
    endtask

    function automatic logic [31:0] mk(input logic [4:0] sub, input logic [4:0] sidx, input logic [4:0] d);
        return {PFX, sub, sidx, d};
    endfunction

    function automatic logic [255:0] rnd();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    // Most negative narrow value repeated for size step sz
    function automatic logic [255:0] neg_pat(input int sz);
        logic [255:0] v = '0;
        for (int b = 0; b < 256; b++) v[b] = ((b % (8 << sz)) == (8 << sz) - 1);
        return v;
    endfunction

    initial begin
        logic [255:0] idx;
        for (int k = 0; k < 32; k++) idx[k*8 +: 8] = 8'(k);
        // R10: reset state
        repeat (3) step(1'b0, '0, '0, 1'b1);
        rst_n = 1'b1;
        // R2 R3 R5: every sub-opcode with random data
        for (int sub = 24; sub < 32; sub++) begin
            tag = (sub[1:0] == 2'b11) ? "R5" : (sub[2] ? "R3" : "R2");
            for (int r = 0; r < 6; r++) step(1'b1, mk(5'(sub), 5'($urandom), 5'($urandom)), rnd(), 1'b1);
        end
        // R4: element placement with byte-index pattern
        tag = "R4";
        for (int sub = 24; sub < 32; sub++) step(1'b1, mk(5'(sub), 5'd3, 5'(sub)), idx, 1'b1);
        // R6: extension corner values
        tag = "R6";
        for (int sub = 24; sub < 32; sub++) begin
            step(1'b1, mk(5'(sub), 5'd1, 5'd2), neg_pat(sub % 4), 1'b1);
            step(1'b1, mk(5'(sub), 5'd1, 5'd2), ~neg_pat(sub % 4), 1'b1);
            step(1'b1, mk(5'(sub), 5'd1, 5'd2), {256{1'b1}}, 1'b1);
        end
        // R1: destination extremes, source field varied
        tag = "R1";
        step(1'b1, mk(5'd24, 5'd31, 5'd31), rnd(), 1'b1);
        step(1'b1, mk(5'd29, 5'd0, 5'd0), rnd(), 1'b1);
        // R7: illegal words keep the data
        tag = "R7";
        step(1'b1, mk(5'd26, 5'd0, 5'd7), rnd(), 1'b1);
        step(1'b1, mk(5'd26, 5'd0, 5'd8) ^ 32'h8000_0000, rnd(), 1'b1);
        step(1'b1, {PFX, 5'b10110, 5'd0, 5'd9}, rnd(), 1'b1);
        step(1'b1, {PFX, 5'b00000, 5'd0, 5'd10}, rnd(), 1'b1);
        step(1'b1, mk(5'd31, 5'd0, 5'd11), rnd(), 1'b1);
        // R9: held back-pressure
        tag = "R9";
        for (int r = 0; r < 5; r++) step(1'b1, mk(5'(24 + r), 5'd0, 5'(r)), rnd(), 1'b0);
        step(1'b1, mk(5'd25, 5'd0, 5'd12), rnd(), 1'b1);
        // R8: random handshake
        tag = "R8";
        for (int r = 0; r < 60; r++)
            step(1'($urandom), mk(5'(24 + ($urandom % 8)), 5'd0, 5'($urandom)), rnd(), 1'($urandom));
        // R10: reset mid-stream
        tag = "R10";
        step(1'b1, mk(5'd27, 5'd0, 5'd13), rnd(), 1'b0);
        rst_n = 1'b0;
        step(1'b1, mk(5'd27, 5'd0, 5'd14), rnd(), 1'b0);
        step(1'b0, '0, '0, 1'b1);
        rst_n = 1'b1;
        repeat (3) step(1'b0, '0, '0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule